// File: doc/BRIEF.md
# CBC Chaining Engine

The engine wraps block-chaining logic around an external 128-bit block cipher. An upstream controller hands it a group descriptor: a direction bit, a chaining bit, an initial vector made of four 32-bit parts, and a word count. The controller then feeds the engine one 128-bit word at a time. Each word leaves through a send stream to the cipher, and the cipher's answer comes back on a return stream. The engine applies the chaining XOR on the correct side of the cipher and hands the processed word back to the controller.

One engine serves both directions and both chaining styles. With chaining off, words pass to and from the cipher unchanged (ECB). With chaining on, encryption mixes each plaintext with the previous ciphertext before sending it. Decryption mixes the cipher output with the previous received ciphertext. The chaining register is reloaded from the descriptor's vector at every group start. Only one word is in flight at a time, because encryption chaining needs the previous result before the next word can be formed.

Top module: `cbc_chain_engine`

## Requirements
- R1: After reset, `busy`, `in_ready`, `out_valid`, `cs_tvalid` and `cr_tready` are 0 and `grp_ready` is 1.
- R2: A descriptor is taken in a cycle where `grp_valid` and `grp_ready` are both 1. For a nonzero count, `busy` is 1 and `grp_ready` is 0 from the next cycle. This lasts until the cycle after the final output handshake, when `busy` returns to 0 and `grp_ready` to 1.
- R3: A descriptor with `grp_count` equal to 0 is accepted without raising `busy`, and no word is requested or sent.
- R4: With `grp_chain`=0 (ECB), the input word is sent to the cipher unchanged and the cipher answer is returned unchanged. In every mode `cs_tuser` equals the group's `grp_encrypt` bit (1 = encrypt, 0 = decrypt).
- R5: With `grp_encrypt`=1 and `grp_chain`=1, the word sent is the input XOR the chaining value. The answer is returned unchanged and becomes the next chaining value.
- R6: With `grp_encrypt`=0 and `grp_chain`=1, the input word is sent unchanged. The returned word is the answer XOR the chaining value, and the input word becomes the next chaining value.
- R7: The chaining value is loaded with `{grp_iv_w3, grp_iv_w2, grp_iv_w1, grp_iv_w0}` (w3 in bits 127:96) when each descriptor is accepted.
- R8: At most one word is in flight. `in_ready` stays 0 from the acceptance of a word until that word's result has been handed back on the output.
- R9: `cs_tvalid`/`cs_tdata` hold steady until `cs_tready`. `out_valid`/`out_data` hold steady until `out_ready`.
- R10: `out_last` is 1 with the final word of a group and 0 with every other word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| grp_valid | input | 1 | Descriptor offered |
| grp_ready | output | 1 | Engine can take a descriptor |
| grp_encrypt | input | 1 | 1 = encrypt, 0 = decrypt |
| grp_chain | input | 1 | 1 = CBC chaining, 0 = ECB |
| grp_iv_w3 | input | 32 | Vector bits 127:96 |
| grp_iv_w2 | input | 32 | Vector bits 95:64 |
| grp_iv_w1 | input | 32 | Vector bits 63:32 |
| grp_iv_w0 | input | 32 | Vector bits 31:0 |
| grp_count | input | 16 | Words in the group |
| in_valid | input | 1 | Input word offered |
| in_ready | output | 1 | Engine takes an input word |
| in_data | input | 128 | Input word |
| out_valid | output | 1 | Processed word offered |
| out_ready | input | 1 | Controller takes the processed word |
| out_data | output | 128 | Processed word |
| out_last | output | 1 | Final word of the group |
| cs_tvalid | output | 1 | Send stream valid |
| cs_tready | input | 1 | Send stream ready |
| cs_tdata | output | 128 | Word to the cipher |
| cs_tuser | output | 1 | Cipher direction, 1 = encrypt |
| cr_tvalid | input | 1 | Return stream valid |
| cr_tready | output | 1 | Return stream ready |
| cr_tdata | input | 128 | Cipher answer |
| busy | output | 1 | Group in progress |

## Verification
The cipher answer's arrival and the chaining register update fall in the same cycle. In decryption, the returned word must be built from the old chaining value while the register takes the saved ciphertext. The bench provokes this with multi-word CBC decryption groups whose cipher model varies its send stall and return latency. It judges the outcome against chained values computed in the bench, including a round trip that must give back the original plaintext. A second overlap is the next input word offered while the previous result is still held back by output backpressure; `in_ready` must stay low throughout.

// File: rtl/cbc_pkg.sv
package cbc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_TAKE = 3'd1,
    ST_SEND = 3'd2,
    ST_WAIT = 3'd3,
    ST_GIVE = 3'd4
  } eng_state_t;

  typedef struct packed {
    logic encrypt;
    logic chain;
  } eng_mode_t;
endpackage

// File: rtl/cbc_seq.sv
module cbc_seq
  import cbc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             grp_valid,
  input  logic [CNT_W-1:0] grp_count,
  input  logic             in_valid,
  input  logic             cs_tready,
  input  logic             cr_tvalid,
  input  logic             out_ready,
  output logic             grp_ready,
  output logic             in_ready,
  output logic             cs_tvalid,
  output logic             cr_tready,
  output logic             out_valid,
  output logic             out_last,
  output logic             busy,
  output logic             load_grp,
  output logic             take_word,
  output logic             ret_word
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  eng_state_t       state_q;
  logic [CNT_W-1:0] left_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      left_q  <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (grp_valid && grp_count != '0) begin
          state_q <= ST_TAKE;
          left_q  <= grp_count;
        end
        ST_TAKE: if (in_valid)  state_q <= ST_SEND;
        ST_SEND: if (cs_tready) state_q <= ST_WAIT;
        ST_WAIT: if (cr_tvalid) state_q <= ST_GIVE;
        ST_GIVE: if (out_ready) begin
          left_q  <= left_q - ONE;
          state_q <= (left_q == ONE) ? ST_IDLE : ST_TAKE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign grp_ready = (state_q == ST_IDLE);
  assign busy      = (state_q != ST_IDLE);
  assign in_ready  = (state_q == ST_TAKE);
  assign cs_tvalid = (state_q == ST_SEND);
  assign cr_tready = (state_q == ST_WAIT);
  assign out_valid = (state_q == ST_GIVE);
  assign out_last  = (state_q == ST_GIVE) && (left_q == ONE);
  assign load_grp  = grp_ready && grp_valid;
  assign take_word = in_ready && in_valid;
  assign ret_word  = cr_tready && cr_tvalid;

  AST_ONE_IN_FLIGHT: assert property (@(posedge clk) disable iff (rst)
    $onehot0({in_ready, cs_tvalid, cr_tready, out_valid})); // R8
  AST_BUSY_END: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> $past(out_valid && out_ready && out_last)); // R2
  AST_ZERO_GROUP: assert property (@(posedge clk) disable iff (rst)
    (grp_valid && grp_ready && grp_count == '0) |=> !busy); // R3
  AST_LAST_CLOSES: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready && out_last) |=> !busy && grp_ready); // R10
endmodule

// File: rtl/cbc_chain_reg.sv
module cbc_chain_reg #(
  parameter int WORD_W = 128
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_iv,
  input  logic [WORD_W-1:0] iv,
  input  logic              upd,
  input  logic [WORD_W-1:0] upd_val,
  output logic [WORD_W-1:0] chain_q
);
  always_ff @(posedge clk) begin
    if (rst)          chain_q <= '0;
    else if (load_iv) chain_q <= iv;
    else if (upd)     chain_q <= upd_val;
  end

  AST_IV_LOAD: assert property (@(posedge clk) disable iff (rst)
    load_iv |=> chain_q == $past(iv)); // R7
endmodule

// File: rtl/cbc_datapath.sv
module cbc_datapath
  import cbc_pkg::*;
#(
  parameter int WORD_W = 128
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_grp,
  input  eng_mode_t         grp_mode,
  input  logic              take_word,
  input  logic [WORD_W-1:0] in_data,
  input  logic              ret_word,
  input  logic [WORD_W-1:0] cr_data,
  input  logic [WORD_W-1:0] chain_q,
  output eng_mode_t         mode_q,
  output logic [WORD_W-1:0] send_q,
  output logic [WORD_W-1:0] result_q,
  output logic [WORD_W-1:0] next_chain
);
  logic [WORD_W-1:0] ct_q;
  logic              pre_xor;
  logic              post_xor;

  assign pre_xor  = mode_q.encrypt && mode_q.chain;
  assign post_xor = !mode_q.encrypt && mode_q.chain;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q   <= '0;
      send_q   <= '0;
      ct_q     <= '0;
      result_q <= '0;
    end else begin
      if (load_grp) mode_q <= grp_mode;
      if (take_word) begin
        send_q <= pre_xor ? (in_data ^ chain_q) : in_data;
        ct_q   <= in_data;
      end
      if (ret_word) result_q <= post_xor ? (cr_data ^ chain_q) : cr_data;
    end
  end

  assign next_chain = mode_q.encrypt ? cr_data : ct_q;

  AST_SAVED_CT: assert property (@(posedge clk) disable iff (rst)
    take_word |=> ct_q == $past(in_data)); // R6
endmodule

// File: rtl/cbc_chain_engine.sv
module cbc_chain_engine
  import cbc_pkg::*;
#(
  parameter int IV_PART_W = 32,
  parameter int CNT_W     = 16
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   grp_valid,
  output logic                   grp_ready,
  input  logic                   grp_encrypt,
  input  logic                   grp_chain,
  input  logic [IV_PART_W-1:0]   grp_iv_w3,
  input  logic [IV_PART_W-1:0]   grp_iv_w2,
  input  logic [IV_PART_W-1:0]   grp_iv_w1,
  input  logic [IV_PART_W-1:0]   grp_iv_w0,
  input  logic [CNT_W-1:0]       grp_count,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic [4*IV_PART_W-1:0] in_data,
  output logic                   out_valid,
  input  logic                   out_ready,
  output logic [4*IV_PART_W-1:0] out_data,
  output logic                   out_last,
  output logic                   cs_tvalid,
  input  logic                   cs_tready,
  output logic [4*IV_PART_W-1:0] cs_tdata,
  output logic                   cs_tuser,
  input  logic                   cr_tvalid,
  output logic                   cr_tready,
  input  logic [4*IV_PART_W-1:0] cr_tdata,
  output logic                   busy
);
  localparam int IV_PARTS = 4;
  localparam int WORD_W   = IV_PARTS * IV_PART_W;

  logic [IV_PART_W-1:0] iv_part [IV_PARTS];
  logic [WORD_W-1:0]    iv_full;
  logic                 load_grp, take_word, ret_word;
  logic [WORD_W-1:0]    chain_q, next_chain;
  eng_mode_t            grp_mode, mode_q;

  assign iv_part[0] = grp_iv_w0;
  assign iv_part[1] = grp_iv_w1;
  assign iv_part[2] = grp_iv_w2;
  assign iv_part[3] = grp_iv_w3;

  for (genvar g = 0; g < IV_PARTS; g++) begin : g_iv
    assign iv_full[g*IV_PART_W +: IV_PART_W] = iv_part[g];
  end

  assign grp_mode.encrypt = grp_encrypt;
  assign grp_mode.chain   = grp_chain;

  cbc_seq #(.CNT_W(CNT_W)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .grp_valid (grp_valid),
    .grp_count (grp_count),
    .in_valid  (in_valid),
    .cs_tready (cs_tready),
    .cr_tvalid (cr_tvalid),
    .out_ready (out_ready),
    .grp_ready (grp_ready),
    .in_ready  (in_ready),
    .cs_tvalid (cs_tvalid),
    .cr_tready (cr_tready),
    .out_valid (out_valid),
    .out_last  (out_last),
    .busy      (busy),
    .load_grp  (load_grp),
    .take_word (take_word),
    .ret_word  (ret_word)
  );

  cbc_chain_reg #(.WORD_W(WORD_W)) u_chain (
    .clk     (clk),
    .rst     (rst),
    .load_iv (load_grp),
    .iv      (iv_full),
    .upd     (ret_word),
    .upd_val (next_chain),
    .chain_q (chain_q)
  );

  cbc_datapath #(.WORD_W(WORD_W)) u_dp (
    .clk        (clk),
    .rst        (rst),
    .load_grp   (load_grp),
    .grp_mode   (grp_mode),
    .take_word  (take_word),
    .in_data    (in_data),
    .ret_word   (ret_word),
    .cr_data    (cr_tdata),
    .chain_q    (chain_q),
    .mode_q     (mode_q),
    .send_q     (cs_tdata),
    .result_q   (out_data),
    .next_chain (next_chain)
  );

  assign cs_tuser = mode_q.encrypt;

  AST_SEND_HOLD: assert property (@(posedge clk) disable iff (rst)
    (cs_tvalid && !cs_tready) |=> cs_tvalid && $stable(cs_tdata)); // R9
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> out_valid && $stable(out_data)); // R9
  AST_ENC_CHAIN: assert property (@(posedge clk) disable iff (rst)
    (ret_word && mode_q.encrypt && mode_q.chain) |=> chain_q == $past(cr_tdata)); // R5
  AST_DEC_RESULT: assert property (@(posedge clk) disable iff (rst)
    (ret_word && !mode_q.encrypt && mode_q.chain) |=> out_data == $past(cr_tdata ^ chain_q)); // R6
  AST_ECB_PASS: assert property (@(posedge clk) disable iff (rst)
    (ret_word && !mode_q.chain) |=> out_data == $past(cr_tdata)); // R4
endmodule

// File: tb/cbc_chain_engine_tb.sv
module cbc_chain_engine_tb;
  localparam logic [127:0] KEY = 128'h0F1E2D3C4B5A69788796A5B4C3D2E1F0;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic grp_valid = 0, grp_encrypt = 0, grp_chain = 0;
  logic [31:0] grp_iv_w3 = 0, grp_iv_w2 = 0, grp_iv_w1 = 0, grp_iv_w0 = 0;
  logic [15:0] grp_count = 0;
  logic in_valid = 0, out_ready = 0, cs_tready, cr_tvalid;
  logic [127:0] in_data = 0, cr_tdata;
  logic grp_ready, in_ready, out_valid, out_last, cs_tvalid, cs_tuser, cr_tready, busy;
  logic [127:0] out_data, cs_tdata;

  cbc_chain_engine u_dut (.*);

  int checks = 0, failures = 0;
  int cs_stall = 0, cr_lat = 0;
  int sent_idx = 0;
  logic [127:0] sent_log [8];
  logic         user_log [8];
  logic [127:0] src [8];
  logic [127:0] dst [8];

  function automatic logic [127:0] c_enc(logic [127:0] x);
    return {x[114:0], x[127:115]} ^ KEY;
  endfunction
  function automatic logic [127:0] c_dec(logic [127:0] y);
    logic [127:0] z = y ^ KEY;
    return {z[12:0], z[127:13]};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // cipher model on the two streams
  initial begin
    logic [127:0] hold;
    logic         dir;
    cs_tready = 0; cr_tvalid = 0; cr_tdata = '0;
    forever begin
      @(negedge clk);
      if (cs_tvalid) begin
        hold = cs_tdata;
        for (int k = 0; k < cs_stall; k++) begin
          @(negedge clk);
          chk(cs_tvalid && cs_tdata == hold, "R9", "send word held", cs_tdata, hold);
        end
        cs_tready = 1;
        dir = cs_tuser;
        if (sent_idx < 8) begin
          sent_log[sent_idx] = cs_tdata;
          user_log[sent_idx] = cs_tuser;
        end
        sent_idx++;
        @(negedge clk);
        cs_tready = 0;
        for (int k = 0; k < cr_lat; k++) @(negedge clk);
        cr_tdata  = dir ? c_enc(hold) : c_dec(hold);
        cr_tvalid = 1;
        while (!cr_tready) @(negedge clk);
        @(negedge clk);
        cr_tvalid = 0;
      end
    end
  end

  task automatic run_group(input bit enc, input bit chn, input logic [127:0] iv,
                           input int n, input int bp);
    logic [127:0] cv, snd, res, d0;
    logic         l0;
    string        tag;
    tag = !chn ? "R4" : (enc ? "R5" : "R6");
    sent_idx = 0;
    grp_encrypt = enc; grp_chain = chn; grp_count = 16'(n);
    {grp_iv_w3, grp_iv_w2, grp_iv_w1, grp_iv_w0} = iv;
    grp_valid = 1;
    while (!grp_ready) @(negedge clk);
    @(negedge clk);
    grp_valid = 0;
    chk(busy && !grp_ready, "R2", "busy after accept", {126'd0, busy, grp_ready}, 128'd2);
    cv = iv;
    in_valid = 1; in_data = src[0];
    for (int i = 0; i < n; i++) begin
      while (!in_ready) @(negedge clk);
      @(negedge clk);
      if (i + 1 < n) in_data = src[i+1];
      else in_valid = 0;
      while (!out_valid) begin
        chk(!in_ready, "R8", "in_ready while word in flight", {127'd0, in_ready}, 128'd0);
        @(negedge clk);
      end
      d0 = out_data; l0 = out_last;
      for (int k = 0; k < bp; k++) begin
        @(negedge clk);
        chk(out_valid && out_data == d0, "R9", "output held", out_data, d0);
        chk(!in_ready, "R8", "in_ready under backpressure", {127'd0, in_ready}, 128'd0);
      end
      out_ready = 1;
      @(negedge clk);
      out_ready = 0;
      dst[i] = d0;
      if (enc) begin
        snd = chn ? (src[i] ^ cv) : src[i];
        res = c_enc(snd);
        if (chn) cv = res;
      end else begin
        snd = src[i];
        res = chn ? (c_dec(src[i]) ^ cv) : c_dec(src[i]);
        cv = src[i];
      end
      chk(sent_log[i] == snd, tag, "word sent to cipher", sent_log[i], snd);
      chk(d0 == res, tag, "returned word", d0, res);
      chk(user_log[i] == enc, "R4", "cipher direction", {127'd0, user_log[i]}, {127'd0, enc});
      chk(l0 == (i == n - 1), "R10", "last flag", {127'd0, l0}, {127'd0, (i == n - 1)});
    end
    chk(!busy && grp_ready, "R2", "idle after last output", {126'd0, busy, grp_ready}, 128'd1);
  endtask

  task automatic fill_src(input logic [31:0] seed);
    for (int i = 0; i < 8; i++)
      src[i] = {seed + 32'(i), ~seed, seed ^ 32'h5A5A_0000, 32'(i * 7 + 3)};
  endtask

  task automatic test_reset();
    chk(!busy && grp_ready && !in_ready && !out_valid && !cs_tvalid && !cr_tready, "R1",
        "reset outputs", {122'd0, busy, grp_ready, in_ready, out_valid, cs_tvalid, cr_tready},
        {122'd0, 6'b010000});
  endtask

  task automatic test_ecb();
    fill_src(32'h1111_0000);
    cs_stall = 0; cr_lat = 1;
    run_group(1'b1, 1'b0, 128'hDEAD, 3, 0);
    run_group(1'b0, 1'b0, 128'hBEEF, 3, 1);
  endtask

  task automatic test_cbc_enc();
    fill_src(32'h2222_0000);
    cs_stall = 2; cr_lat = 3;
    run_group(1'b1, 1'b1, 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210, 5, 2);
  endtask

  task automatic test_cbc_dec();
    fill_src(32'h3333_0000);
    cs_stall = 1; cr_lat = 0;
    run_group(1'b0, 1'b1, 128'hA5A5_0000_1111_2222_3333_4444_5555_6666, 4, 3);
  endtask

  task automatic test_roundtrip();
    logic [127:0] plain [8];
    logic [127:0] iv = 128'h00000001_00000002_00000003_00000004;
    fill_src(32'h4444_0000);
    for (int i = 0; i < 8; i++) plain[i] = src[i];
    cs_stall = 0; cr_lat = 2;
    run_group(1'b1, 1'b1, iv, 6, 0);
    for (int i = 0; i < 6; i++) src[i] = dst[i];
    run_group(1'b0, 1'b1, iv, 6, 1);
    for (int i = 0; i < 6; i++)
      chk(dst[i] == plain[i], "R6", "round trip plaintext", dst[i], plain[i]);
  endtask

  task automatic test_reload();
    logic [127:0] first;
    fill_src(32'h5555_0000);
    cs_stall = 0; cr_lat = 0;
    run_group(1'b1, 1'b1, 128'h77, 1, 0);
    first = dst[0];
    run_group(1'b1, 1'b1, 128'h77, 1, 0);
    chk(dst[0] == first, "R7", "same vector gives same first word", dst[0], first);
    run_group(1'b1, 1'b1, 128'hFFFF_0000_0000_0000_0000_0000_0000_0001, 2, 0);
    chk(dst[0] == c_enc(src[0] ^ 128'hFFFF_0000_0000_0000_0000_0000_0000_0001), "R7",
        "new vector with w3 as top bits", dst[0],
        c_enc(src[0] ^ 128'hFFFF_0000_0000_0000_0000_0000_0000_0001));
  endtask

  task automatic test_zero();
    grp_count = 0; grp_encrypt = 1; grp_chain = 1; grp_valid = 1;
    while (!grp_ready) @(negedge clk);
    @(negedge clk);
    grp_valid = 0;
    for (int k = 0; k < 4; k++) begin
      chk(!busy && grp_ready && !in_ready && !cs_tvalid, "R3", "zero-length group",
          {124'd0, busy, grp_ready, in_ready, cs_tvalid}, {124'd0, 4'b0100});
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    @(negedge clk);
    test_reset();
    test_ecb();
    test_cbc_enc();
    test_cbc_dec();
    test_roundtrip();
    test_reload();
    test_zero();
    repeat (4) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule